// File: doc/BRIEF.md
# Interrupt context save sequencer

This block carries out the hardware half of interrupt entry. On an accept pulse it captures a 20-bit program counter, a 16-bit flag word and one of two stack pointers. It then writes a four-byte frame downward from that pointer through a 16-bit little-endian data port. The port takes a byte address, a write strobe, two byte enables and a 16-bit data word.

The pointer is the user stack pointer only for software interrupts numbered 32 to 63. Every other request uses the interrupt stack pointer. When the chosen pointer is even, the frame goes out as two aligned word writes. When it is odd, it goes out as four single-byte writes. One cycle after the last write the block pulses done and presents the decremented pointer, along with a flag that says which pointer it belongs to. The core writes that value back into the pointer it selected.

Top module: `ctx_save_seq`

## Requirements
- R1: The base pointer is `usp_i` when `sw_int_i` is 1 and `int_num_i` is in 32..63. Otherwise it is `isp_i`. `sp_sel_o` reports 1 for the user pointer and 0 for the interrupt pointer. It is valid from the done pulse until the next done pulse.
- R2: The frame bytes, with P = base pointer, are:
  - P-1 = {flg[15:12], pc[19:16]}
  - P-2 = flg[7:0]
  - P-3 = pc[15:8]
  - P-4 = pc[7:0]
- R3: For an even P, there is one write in each of the two cycles that follow the accept edge, and both are word writes with `mem_be_o`=2'b11.
  - The first write goes to P-2 with data {flg[15:12],pc[19:16],flg[7:0]}.
  - The second write goes to P-4 with data pc[15:0].
- R4: For an odd P, there is one byte write in each of the four cycles after the accept edge, to P-1, P-2, P-3 and P-4 in that order.
  - Address bit 0 equal to 0 selects lane 0: `mem_be_o`=2'b01, byte on data[7:0].
  - Address bit 0 equal to 1 selects lane 1: `mem_be_o`=2'b10, byte on data[15:8].
- R5: `done_o` is high for exactly the one cycle after the last write. From that cycle on, `sp_o` equals P-4.
- R6: An accept that arrives while writes are in progress has no effect on the writes, on `sp_o` or on `sp_sel_o`.
- R7: While `rst_ni` is low, and in the first cycle after reset, there are no writes, `done_o` is 0, `sp_o` is 0 and `sp_sel_o` is 0.
- R8: Pointer arithmetic wraps modulo 2^AW. For example, P=2 leaves `sp_o`=16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted, one-cycle pulse |
| sw_int_i | input | 1 | Request comes from a software interrupt instruction |
| int_num_i | input | 6 | Interrupt number |
| pc_i | input | 20 | Program counter to save |
| flg_i | input | 16 | Flag register to save |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Byte address of the write |
| mem_be_o | output | 2 | Byte lane enables |
| mem_wdata_o | output | 16 | Write data |
| sp_o | output | 16 | Updated stack pointer |
| sp_sel_o | output | 1 | 1: `sp_o` is the user pointer, 0: the interrupt pointer |
| done_o | output | 1 | Save complete, one-cycle pulse |

## Verification
The assertions check four rules on every cycle:
- Even-pointer writes are aligned and use both byte lanes.
- Odd-pointer writes enable exactly the lane that address bit 0 selects.
- Done follows a write and lasts a single cycle.
- The returned pointer equals the address of the last write.

Frame contents, write order, pointer selection at the 31/32 boundary, the ignored mid-save accept and address wrap all depend on the values requested. Only the bench's reference model shows these, by comparing every output on every cycle.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;
  typedef enum logic {ST_IDLE, ST_SAVE} state_e;

  // bN is the byte stored at pointer-N
  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] b3;
    logic [7:0] b4;
  } frame_t;
endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
  parameter int AW     = 16,
  parameter int NUM_W  = 6,
  parameter int USR_LO = 32
) (
  input  logic             sw_int_i,
  input  logic [NUM_W-1:0] int_num_i,
  input  logic [AW-1:0]    isp_i,
  input  logic [AW-1:0]    usp_i,
  output logic [AW-1:0]    sp_o,
  output logic             use_usp_o
);
  localparam int NUM_MAX = (1 << NUM_W) - 1;

  always_comb begin
    use_usp_o = sw_int_i && (int'(int_num_i) >= USR_LO) && (int'(int_num_i) <= NUM_MAX);
    sp_o      = use_usp_o ? usp_i : isp_i;
  end
endmodule

// File: rtl/ctx_frame_pack.sv
module ctx_frame_pack
  import ctx_save_pkg::*;
#(
  parameter int PCW = 20,
  parameter int FW  = 16
) (
  input  logic [PCW-1:0] pc_i,
  input  logic [FW-1:0]  flg_i,
  output frame_t         frame_o
);
  localparam int PC_HI = PCW - 16;  // high PC bits above the low 16
  localparam int FL_HI = 4;         // flag bits kept above the low byte

  logic [3:0] pc_top;
  logic [3:0] flg_top;

  always_comb begin
    pc_top  = 4'(pc_i[PCW-1 -: PC_HI]);
    flg_top = flg_i[FW-1 -: FL_HI];
    frame_o.b1 = {flg_top, pc_top};
    frame_o.b2 = flg_i[7:0];
    frame_o.b3 = pc_i[15:8];
    frame_o.b4 = pc_i[7:0];
  end
endmodule

// File: rtl/ctx_save_fsm.sv
module ctx_save_fsm
  import ctx_save_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] base_i,
  input  logic          use_usp_i,
  input  frame_t        frame_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o,
  output logic [AW-1:0] sp_o,
  output logic          sp_sel_o,
  output logic          done_o
);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(4);

  state_e        state_q;
  logic [1:0]    step_q;
  logic [AW-1:0] base_q;
  logic          odd_q;
  frame_t        frame_q;
  logic          sel_q;
  logic [AW-1:0] sp_q;
  logic          sp_sel_q;
  logic          done_q;
  logic          last;
  logic [AW-1:0] off;
  logic [7:0]    cur_byte;

  always_comb begin
    last = odd_q ? (step_q == 2'd3) : (step_q == 2'd1);
    off  = odd_q ? AW'({1'b0, step_q} + 3'd1) : AW'(({1'b0, step_q} + 3'd1) << 1);
    unique case (step_q)
      2'd0:    cur_byte = frame_q.b1;
      2'd1:    cur_byte = frame_q.b2;
      2'd2:    cur_byte = frame_q.b3;
      default: cur_byte = frame_q.b4;
    endcase
    mem_we_o   = (state_q == ST_SAVE);
    mem_addr_o = base_q - off;
    if (!odd_q) begin
      mem_be_o    = 2'b11;
      mem_wdata_o = (step_q == 2'd0) ? {frame_q.b1, frame_q.b2} : {frame_q.b3, frame_q.b4};
    end else begin
      mem_be_o    = mem_addr_o[0] ? 2'b10 : 2'b01;
      mem_wdata_o = {cur_byte, cur_byte};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      base_q   <= '0;
      odd_q    <= 1'b0;
      frame_q  <= '0;
      sel_q    <= 1'b0;
      sp_q     <= '0;
      sp_sel_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          state_q <= ST_SAVE;
          step_q  <= '0;
          base_q  <= base_i;
          odd_q   <= base_i[0];
          frame_q <= frame_i;
          sel_q   <= use_usp_i;
        end
        default: begin
          if (last) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            sp_q     <= base_q - FRAME_BYTES;
            sp_sel_q <= sel_q;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
      endcase
    end
  end

  assign sp_o     = sp_q;
  assign sp_sel_o = sp_sel_q;
  assign done_o   = done_q;

  a_r3_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !odd_q) |-> (mem_be_o == 2'b11 && !mem_addr_o[0]));
  a_r4_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && odd_q) |-> ($countones(mem_be_o) == 1 && mem_be_o[1] == mem_addr_o[0]));
  a_r5_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_we_o) && !mem_we_o));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_sp_last_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sp_o == $past(mem_addr_o)));
  a_r6_base_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && accept_i) |=> $stable(base_q));
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PCW   = 20,
  parameter int FW    = 16,
  parameter int NUM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             sw_int_i,
  input  logic [NUM_W-1:0] int_num_i,
  input  logic [PCW-1:0]   pc_i,
  input  logic [FW-1:0]    flg_i,
  input  logic [AW-1:0]    isp_i,
  input  logic [AW-1:0]    usp_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [1:0]       mem_be_o,
  output logic [15:0]      mem_wdata_o,
  output logic [AW-1:0]    sp_o,
  output logic             sp_sel_o,
  output logic             done_o
);
  logic [AW-1:0] base;
  logic          use_usp;
  frame_t        frame;

  ctx_sp_select #(.AW(AW), .NUM_W(NUM_W), .USR_LO(32)) u_sel (
    .sw_int_i (sw_int_i),
    .int_num_i(int_num_i),
    .isp_i    (isp_i),
    .usp_i    (usp_i),
    .sp_o     (base),
    .use_usp_o(use_usp)
  );

  ctx_frame_pack #(.PCW(PCW), .FW(FW)) u_pack (
    .pc_i   (pc_i),
    .flg_i  (flg_i),
    .frame_o(frame)
  );

  ctx_save_fsm #(.AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept_i),
    .base_i     (base),
    .use_usp_i  (use_usp),
    .frame_i    (frame),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_wdata_o(mem_wdata_o),
    .sp_o       (sp_o),
    .sp_sel_o   (sp_sel_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/tb_ctx_save_seq.sv
module tb_ctx_save_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0;
  logic        sw_int = 1'b0;
  logic [5:0]  int_num = '0;
  logic [19:0] pc = '0;
  logic [15:0] flg = '0;
  logic [15:0] isp = '0;
  logic [15:0] usp = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] sp;
  logic        sp_sel;
  logic        done;

  always #4 clk = ~clk;  // 125 MHz

  ctx_save_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept), .sw_int_i(sw_int),
    .int_num_i(int_num), .pc_i(pc), .flg_i(flg), .isp_i(isp), .usp_i(usp),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .sp_o(sp), .sp_sel_o(sp_sel), .done_o(done)
  );

  typedef struct {
    bit        we;
    bit [15:0] addr;
    bit [1:0]  be;
    bit [15:0] data;
    bit        done;
    bit [15:0] sp;
    bit        sel;
  } cyc_t;

  cyc_t      exp_q[$];
  int        n_tests = 0;
  int        n_fail = 0;
  bit        last_we = 0;
  bit        checking = 0;
  bit [15:0] held_sp = '0;
  bit        held_sel = 0;
  bit        finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Cycle-by-cycle comparison against the queued expectations
  always @(negedge clk) begin
    if (checking) begin
      cyc_t e;
      bit [15:0] m;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e.we = 0; e.addr = 0; e.be = 0; e.data = 0; e.done = 0;
        e.sp = held_sp; e.sel = held_sel;
      end
      last_we = e.we;
      if (e.done) begin held_sp = e.sp; held_sel = e.sel; end
      chk(mem_we == e.we, e.we ? (e.be == 2'b11 ? "R3 we" : "R4 we") : "R6 no write", int'(mem_we), int'(e.we));
      if (e.we && mem_we) begin
        m = {{8{e.be[1]}}, {8{e.be[0]}}};
        chk(mem_addr == e.addr, e.be == 2'b11 ? "R3 addr" : "R4 addr", int'(mem_addr), int'(e.addr));
        chk(mem_be == e.be, e.be == 2'b11 ? "R3 be" : "R4 be", int'(mem_be), int'(e.be));
        chk((mem_wdata & m) == (e.data & m), "R2 data", int'(mem_wdata & m), int'(e.data & m));
      end
      chk(done == e.done, "R5 done", int'(done), int'(e.done));
      chk(sp == e.sp, "R5 sp", int'(sp), int'(e.sp));
      chk(sp_sel == e.sel, "R1 sel", int'(sp_sel), int'(e.sel));
    end
  end

  function automatic bit [7:0] fbyte(input bit [19:0] p, input bit [15:0] f, input int k);
    case (k)
      1: return {f[15:12], p[19:16]};
      2: return f[7:0];
      3: return p[15:8];
      default: return p[7:0];
    endcase
  endfunction

  task automatic req(input bit [19:0] p, input bit [15:0] f, input bit [15:0] i_sp,
                     input bit [15:0] u_sp, input bit sw, input bit [5:0] num);
    bit        use_u;
    bit [15:0] b;
    cyc_t      c;
    @(negedge clk); #1;
    pc = p; flg = f; isp = i_sp; usp = u_sp; sw_int = sw; int_num = num; accept = 1;
    if (!last_we) begin
      use_u = sw && (num >= 32);
      b = use_u ? u_sp : i_sp;
      c.done = 0; c.sp = held_sp; c.sel = held_sel;
      if (!b[0]) begin
        c.we = 1; c.be = 2'b11;
        c.addr = b - 16'd2; c.data = {fbyte(p, f, 1), fbyte(p, f, 2)}; exp_q.push_back(c);
        c.addr = b - 16'd4; c.data = p[15:0]; exp_q.push_back(c);
      end else begin
        for (int k = 1; k <= 4; k++) begin
          c.we = 1; c.addr = b - 16'(k);
          c.be = c.addr[0] ? 2'b10 : 2'b01;
          c.data = {fbyte(p, f, k), fbyte(p, f, k)};
          exp_q.push_back(c);
        end
      end
      c.we = 0; c.be = 0; c.addr = 0; c.data = 0; c.done = 1; c.sp = b - 16'd4; c.sel = use_u;
      exp_q.push_back(c);
    end
    @(negedge clk); #1;
    accept = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      finish_run();
    end
  end

  initial begin
    // R7: reset state, also with accept held high during reset
    accept = 1; isp = 16'h0100;
    repeat (3) @(negedge clk);
    chk(!mem_we && !done, "R7 reset outputs", int'({mem_we, done}), 0);
    chk(sp == 0 && !sp_sel, "R7 reset sp", int'(sp), 0);
    accept = 0;
    rst_n = 1;
    @(negedge clk); #1;
    checking = 1;
    // R3 even interrupt pointer
    req(20'hABCDE, 16'h7F35, 16'h0400, 16'h0800, 0, 6'd10);
    drain();
    // R4 odd interrupt pointer
    req(20'h12345, 16'hA0C6, 16'h0401, 16'h0800, 0, 6'd3);
    drain();
    // R1 boundary: 31 -> interrupt pointer, 32 and 63 -> user pointer, hw 40 -> interrupt
    req(20'h0F0F0, 16'h1111, 16'h0300, 16'h0901, 1, 6'd31);
    drain();
    chk(sp == 16'h02FC && !sp_sel, "R1 num 31 uses isp", int'(sp), 16'h02FC);
    req(20'hFFFFF, 16'hFFFF, 16'h0300, 16'h0901, 1, 6'd32);
    drain();
    chk(sp == 16'h08FD && sp_sel, "R1 num 32 uses usp", int'(sp), 16'h08FD);
    req(20'h55AA5, 16'h9081, 16'h0300, 16'h0A00, 1, 6'd63);
    drain();
    req(20'h55AA5, 16'h9081, 16'h0302, 16'h0A00, 0, 6'd40);
    drain();
    chk(sp == 16'h02FE && !sp_sel, "R1 hw 40 uses isp", int'(sp), 16'h02FE);
    // R6 accept during save is ignored
    req(20'h13579, 16'h2468, 16'h0500, 16'h0000, 0, 6'd1);
    req(20'h99999, 16'h9999, 16'h0777, 16'h0777, 1, 6'd50);
    drain();
    chk(sp == 16'h04FC && !sp_sel, "R6 second accept ignored", int'(sp), 16'h04FC);
    req(20'h24680, 16'h3C3C, 16'h0603, 16'h0000, 0, 6'd2);
    req(20'h11111, 16'h1111, 16'h0700, 16'h0000, 0, 6'd2);
    req(20'h22222, 16'h2222, 16'h0700, 16'h0000, 0, 6'd2);
    drain();
    // back-to-back: new accept in the done cycle is taken
    req(20'h00001, 16'h0002, 16'h0010, 16'h0000, 0, 6'd0);
    repeat (1) @(negedge clk);
    req(20'h00003, 16'h0004, 16'h0021, 16'h0000, 0, 6'd0);
    drain();
    // R8 wrap below zero
    req(20'hCAFEB, 16'hB00C, 16'h0002, 16'h0000, 0, 6'd0);
    drain();
    chk(sp == 16'hFFFE, "R8 even wrap", int'(sp), 16'hFFFE);
    req(20'hCAFEB, 16'hB00C, 16'h0001, 16'h0000, 0, 6'd0);
    drain();
    chk(sp == 16'hFFFD, "R8 odd wrap", int'(sp), 16'hFFFD);
    finish_run();
  end
endmodule